// File: doc/BRIEF.md
# Composite Video Raster Timing Generator

This block produces the digital timing for a monochrome 320 by 240 picture shown on a composite television input. It runs from a 16 MHz master clock, divides it down to an 8 MHz pixel slot, and counts slots across each scan line and lines down each field. From those two counts it decodes horizontal sync, vertical sync, a blanking flag, a pixel-enable window and the pixel coordinates. A frame-buffer reader uses the coordinates to fetch the pixel for each slot. The analog stage that mixes sync levels into the video signal is not part of the block.

The 320-pixel window lasts 40 us. It sits in the middle of the visible part of each line, so the whole picture stays on screen with margin on both sides. Vertically, the 240 active lines are centred within the picture lines of a field. A parameter selects the 525-line or the 625-line frame. Each frame is built from two fields of unequal length: one line longer, then one line shorter. A parity output tells the reader which field is being scanned, and a short pulse marks the start of every field.

Time below is counted in pixel slots. One slot is PIX_DIV master clocks. One 4 MHz timing tick is two slots.

Top module: `cvt_timing_gen`

## Requirements
- R1: The slot counter advances once every PIX_DIV master clocks (default 2, giving 8 MHz from 16 MHz). With PIX_DIV=2, the first advance after reset release occurs on the second rising edge.
- R2: A line lasts 508 slots (63.5 us) in 525-line mode and 512 slots (64 us) in 625-line mode. The slot count then returns to 0 and the next line begins.
- R3: hsync_n is low during slots 0 to 37 of every line (19 ticks, about 4.7 us) and high for the rest of the line.
- R4: field_odd is 0 for the first field after reset. It toggles at the end of every field. A field with field_odd=0 holds 263 lines (525 mode) or 313 lines (625 mode). A field with field_odd=1 holds 262 or 312 lines.
- R5: vsync_n is low throughout lines 0 to 2 of every field and high on all other lines.
- R6: pix_en is high exactly when both of these hold:
  - the slot is in 126..445 (525 mode) or 132..451 (625 mode);
  - the line of the field is in 21..260 (525 mode) or 48..287 (625 mode).

  This gives 320 slots by 240 lines.
- R7: blank is the inverse of pix_en. pix_en is never high while hsync_n or vsync_n is low.
- R8: field_start is high during slots 0 and 1 of line 0 of every field (one tick) and low at all other times.
- R9: pix_x equals the slot number minus the window's first slot while pix_en is high, so it runs 0 to 319. At all other times pix_x is 0.
- R10: pix_y is 0 before the first active line of a field. It equals the line number minus the first active line during the active lines. It holds 239 after the last active line, and returns to 0 when the next field starts.
- R11: While rst_n is low, the outputs take these values: hsync_n=0, vsync_n=0, blank=1, pix_en=0, field_start=1, field_odd=0, pix_x=0, pix_y=0. This is the state of slot 0, line 0 of the first field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 16 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low, whole lines |
| blank | output | 1 | High outside the active picture |
| pix_en | output | 1 | High in the 320x240 active window |
| field_start | output | 1 | One-tick pulse at the start of each field |
| field_odd | output | 1 | Field parity, toggles each field |
| pix_x | output | 9 | Pixel column, 0 to 319 |
| pix_y | output | 8 | Pixel row, 0 to 239 |

## Verification
All outputs are decoded combinationally from the slot and line counters, or are the x and y counters themselves. Each output therefore reflects a slot during the same clock in which the counter holds that slot. After reset release, the counters move one slot per PIX_DIV rising edges. The bench counts rising edges since reset release and samples on the falling edge between them. It derives the current slot, line and field from that count: the count itself when PIX_DIV is 1, and half the count when PIX_DIV is 2. The expected outputs are computed from those values before comparison, so every check lands on the cycle in which the value is due.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int ACT_W       = 320;
  localparam int ACT_H       = 240;
  localparam int X_W         = 9;
  localparam int Y_W         = 8;
  localparam int HSYNC_SLOTS = 38;
  localparam int TICK_SLOTS  = 2;
  localparam int VSYNC_LINES = 3;
  localparam int VIS_BEGIN   = 84;

  function automatic int line_slots(input bit m625);
    return m625 ? 512 : 508;
  endfunction

  function automatic int vis_end(input bit m625);
    return m625 ? 500 : 488;
  endfunction

  function automatic int field_lines(input bit m625, input bit second);
    if (m625) return second ? 312 : 313;
    return second ? 262 : 263;
  endfunction

  function automatic int vblank_lines(input bit m625);
    return m625 ? 25 : 21;
  endfunction

  function automatic int act_col0(input bit m625);
    return (VIS_BEGIN + vis_end(m625) - ACT_W) / 2;
  endfunction

  function automatic int act_row0(input bit m625);
    return vblank_lines(m625) + (field_lines(m625, 1'b1) - vblank_lines(m625) - ACT_H) / 2;
  endfunction
endpackage

// File: rtl/cvt_prescale.sv
module cvt_prescale #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic stb
);
  generate
    if (DIV <= 1) begin : g_pass
      assign stb = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q, cnt_d;

      assign stb = (cnt_q == LAST);

      always_comb begin
        cnt_d = stb ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate
endmodule

// File: rtl/cvt_hcount.sv
module cvt_hcount
  import cvt_pkg::*;
#(
  parameter bit LINES_625 = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic line_end,
  output logic first_tick,
  output logic hsync_n,
  output logic h_act
);
  localparam int HT = line_slots(LINES_625);
  localparam int HW = $clog2(HT);
  localparam int AC = act_col0(LINES_625);
  localparam logic [HW-1:0] H_LAST   = HW'(HT - 1);
  localparam logic [HW-1:0] SYNC_END = HW'(HSYNC_SLOTS);
  localparam logic [HW-1:0] TICK_END = HW'(TICK_SLOTS);
  localparam logic [HW-1:0] A_BEG    = HW'(AC);
  localparam logic [HW-1:0] A_END    = HW'(AC + ACT_W);

  logic [HW-1:0] h_q, h_d;

  always_comb begin
    h_d = (h_q == H_LAST) ? '0 : h_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   h_q <= '0;
    else if (stb) h_q <= h_d;
  end

  assign line_end   = stb && (h_q == H_LAST);
  assign first_tick = (h_q < TICK_END);
  assign hsync_n    = !(h_q < SYNC_END);
  assign h_act      = (h_q >= A_BEG) && (h_q < A_END);

  // R1
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(h_q));
  // R2
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (h_q == '0));
endmodule

// File: rtl/cvt_vcount.sv
module cvt_vcount
  import cvt_pkg::*;
#(
  parameter bit LINES_625 = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_end,
  output logic field_end,
  output logic first_line,
  output logic vsync_n,
  output logic v_act,
  output logic field_odd
);
  localparam int FL0 = field_lines(LINES_625, 1'b0);
  localparam int FL1 = field_lines(LINES_625, 1'b1);
  localparam int VW  = $clog2(FL0);
  localparam int AR  = act_row0(LINES_625);
  localparam logic [VW-1:0] LAST0    = VW'(FL0 - 1);
  localparam logic [VW-1:0] LAST1    = VW'(FL1 - 1);
  localparam logic [VW-1:0] VS_END   = VW'(VSYNC_LINES);
  localparam logic [VW-1:0] ROW_BEG  = VW'(AR);
  localparam logic [VW-1:0] ROW_END  = VW'(AR + ACT_H);

  logic [VW-1:0] v_q, v_d;
  logic          odd_q, odd_d;
  logic [VW-1:0] last_line;

  assign last_line = odd_q ? LAST1 : LAST0;
  assign field_end = line_end && (v_q == last_line);

  always_comb begin
    v_d   = field_end ? '0 : v_q + 1'b1;
    odd_d = field_end ? !odd_q : odd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      odd_q <= 1'b0;
    end else if (line_end) begin
      v_q   <= v_d;
      odd_q <= odd_d;
    end
  end

  assign first_line = (v_q == '0);
  assign vsync_n    = !(v_q < VS_END);
  assign v_act      = (v_q >= ROW_BEG) && (v_q < ROW_END);
  assign field_odd  = odd_q;

  // R4
  parity_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_end |=> (field_odd != $past(field_odd)));
  // R4
  parity_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !field_end |=> $stable(field_odd));
endmodule

// File: rtl/cvt_coord.sv
module cvt_coord
  import cvt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stb,
  input  logic           line_end,
  input  logic           field_end,
  input  logic           de,
  input  logic           v_act,
  output logic [X_W-1:0] pix_x,
  output logic [Y_W-1:0] pix_y
);
  localparam logic [X_W-1:0] X_MAX = X_W'(ACT_W - 1);
  localparam logic [Y_W-1:0] Y_MAX = Y_W'(ACT_H - 1);

  logic [X_W-1:0] x_q, x_d;
  logic [Y_W-1:0] y_q, y_d;

  always_comb begin
    x_d = (de && (x_q != X_MAX)) ? x_q + 1'b1 : '0;
    if (field_end)                  y_d = '0;
    else if (v_act && (y_q != Y_MAX)) y_d = y_q + 1'b1;
    else                            y_d = y_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   x_q <= '0;
    else if (stb) x_q <= x_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        y_q <= '0;
    else if (line_end) y_q <= y_d;
  end

  assign pix_x = x_q;
  assign pix_y = y_q;

  // R9
  x_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (x_q <= X_MAX));
  // R10
  y_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_end |=> (y_q == '0));
endmodule

// File: rtl/cvt_timing_gen.sv
module cvt_timing_gen
  import cvt_pkg::*;
#(
  parameter bit LINES_625 = 1'b0,
  parameter int PIX_DIV   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           hsync_n,
  output logic           vsync_n,
  output logic           blank,
  output logic           pix_en,
  output logic           field_start,
  output logic           field_odd,
  output logic [X_W-1:0] pix_x,
  output logic [Y_W-1:0] pix_y
);
  logic stb, line_end, first_tick, h_act;
  logic field_end, first_line, v_act;

  cvt_prescale #(.DIV(PIX_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .stb(stb)
  );

  cvt_hcount #(.LINES_625(LINES_625)) u_h (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .line_end(line_end), .first_tick(first_tick),
    .hsync_n(hsync_n), .h_act(h_act)
  );

  cvt_vcount #(.LINES_625(LINES_625)) u_v (
    .clk(clk), .rst_n(rst_n), .line_end(line_end),
    .field_end(field_end), .first_line(first_line),
    .vsync_n(vsync_n), .v_act(v_act), .field_odd(field_odd)
  );

  assign pix_en      = h_act && v_act;
  assign blank       = !pix_en;
  assign field_start = first_line && first_tick;

  cvt_coord u_xy (
    .clk(clk), .rst_n(rst_n), .stb(stb), .line_end(line_end),
    .field_end(field_end), .de(pix_en), .v_act(v_act),
    .pix_x(pix_x), .pix_y(pix_y)
  );

  // R7
  en_vs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |-> (hsync_n && vsync_n));
  // R8
  start_in_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |-> !vsync_n);
endmodule

// File: tb/cvt_timing_gen_test.sv
module cvt_timing_gen_test;
  localparam int CLK_PERIOD = 62;
  localparam int RUN_CYCLES = 160400;
  localparam int WDOG_CYCLES = 195000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   n = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   chk_on = 1'b0;
  bit   done = 1'b0;

  logic a_hs, a_vs, a_bl, a_de, a_fs, a_fo;
  logic [8:0] a_x;
  logic [7:0] a_y;
  logic b_hs, b_vs, b_bl, b_de, b_fs, b_fo;
  logic [8:0] b_x;
  logic [7:0] b_y;
  logic c_hs, c_vs, c_bl, c_de, c_fs, c_fo;
  logic [8:0] c_x;
  logic [7:0] c_y;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvt_timing_gen #(.LINES_625(1'b0), .PIX_DIV(1)) uut (
    .clk(clk), .rst_n(rst_n), .hsync_n(a_hs), .vsync_n(a_vs), .blank(a_bl),
    .pix_en(a_de), .field_start(a_fs), .field_odd(a_fo), .pix_x(a_x), .pix_y(a_y)
  );
  cvt_timing_gen #(.LINES_625(1'b1), .PIX_DIV(1)) uut625 (
    .clk(clk), .rst_n(rst_n), .hsync_n(b_hs), .vsync_n(b_vs), .blank(b_bl),
    .pix_en(b_de), .field_start(b_fs), .field_odd(b_fo), .pix_x(b_x), .pix_y(b_y)
  );
  cvt_timing_gen uut_div (
    .clk(clk), .rst_n(rst_n), .hsync_n(c_hs), .vsync_n(c_vs), .blank(c_bl),
    .pix_en(c_de), .field_start(c_fs), .field_odd(c_fo), .pix_x(c_x), .pix_y(c_y)
  );

  always @(posedge clk) begin
    if (!rst_n) n <= 0;
    else        n <= n + 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", req, what, act, exp, n);
    end
  endtask

  // Expected outputs from the requirement numbers only.
  task automatic model(input bit m625, input int p,
                       output int hs, output int vs, output int de, output int fs,
                       output int fo, output int x, output int y);
    int ht, fl0, fl1, r0, c0, ltot, h, lf, line;
    ht  = m625 ? 512 : 508;            // R2
    fl0 = m625 ? 313 : 263;            // R4
    fl1 = m625 ? 312 : 262;
    r0  = m625 ? 48 : 21;              // R6
    c0  = m625 ? 132 : 126;
    ltot = p / ht;
    h    = p % ht;
    lf   = ltot % (fl0 + fl1);
    fo   = (lf >= fl0) ? 1 : 0;
    line = fo ? lf - fl0 : lf;
    hs   = (h < 38) ? 0 : 1;
    vs   = (line < 3) ? 0 : 1;
    de   = (h >= c0 && h < c0 + 320 && line >= r0 && line < r0 + 240) ? 1 : 0;
    fs   = (line == 0 && h < 2) ? 1 : 0;
    x    = de ? h - c0 : 0;
    if (line < r0)            y = 0;
    else if (line < r0 + 240) y = line - r0;
    else                      y = 239;
  endtask

  task automatic cmp(input string who, input bit m625, input int p,
                     input logic hs, input logic vs, input logic bl, input logic de,
                     input logic fs, input logic fo, input logic [8:0] x, input logic [7:0] y);
    int ehs, evs, ede, efs, efo, ex, ey;
    model(m625, p, ehs, evs, ede, efs, efo, ex, ey);
    check("R3", {who, " hsync_n"}, int'(hs), ehs);
    check("R5", {who, " vsync_n"}, int'(vs), evs);
    check("R6", {who, " pix_en"}, int'(de), ede);
    check("R7", {who, " blank"}, int'(bl), 1 - ede);
    check("R8", {who, " field_start"}, int'(fs), efs);
    check("R4", {who, " field_odd"}, int'(fo), efo);
    check("R9", {who, " pix_x"}, int'(x), ex);
    check("R10", {who, " pix_y"}, int'(y), ey);
  endtask

  task automatic check_reset(input string who, input logic hs, input logic vs, input logic bl,
                             input logic de, input logic fs, input logic fo,
                             input logic [8:0] x, input logic [7:0] y);
    check("R11", {who, " reset hsync_n"}, int'(hs), 0);
    check("R11", {who, " reset vsync_n"}, int'(vs), 0);
    check("R11", {who, " reset blank"}, int'(bl), 1);
    check("R11", {who, " reset pix_en"}, int'(de), 0);
    check("R11", {who, " reset field_start"}, int'(fs), 1);
    check("R11", {who, " reset field_odd"}, int'(fo), 0);
    check("R11", {who, " reset pix_x"}, int'(x), 0);
    check("R11", {who, " reset pix_y"}, int'(y), 0);
  endtask

  task automatic reset_all;
    check_reset("uut", a_hs, a_vs, a_bl, a_de, a_fs, a_fo, a_x, a_y);
    check_reset("uut625", b_hs, b_vs, b_bl, b_de, b_fs, b_fo, b_x, b_y);
    check_reset("uut_div", c_hs, c_vs, c_bl, c_de, c_fs, c_fo, c_x, c_y);
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      cmp("uut", 1'b0, n, a_hs, a_vs, a_bl, a_de, a_fs, a_fo, a_x, a_y);
      cmp("uut625", 1'b1, n, b_hs, b_vs, b_bl, b_de, b_fs, b_fo, b_x, b_y);
      // R1: default divider, one slot per two edges
      cmp("uut_div", 1'b0, n / 2, c_hs, c_vs, c_bl, c_de, c_fs, c_fo, c_x, c_y);
      if (n == 75 || n == 76)
        check("R1", "uut_div hsync_n at slot 37/38", int'(c_hs), (n == 76) ? 1 : 0);
      if (n == 507 || n == 508)
        check("R2", "uut line wrap hsync_n", int'(a_hs), (n == 508) ? 0 : 1);
      if (n == 511 || n == 512)
        check("R2", "uut625 line wrap hsync_n", int'(b_hs), (n == 512) ? 0 : 1);
    end
  end

  task automatic finish_run;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    int first_run;
    int hold;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1 reset_all();
    @(negedge clk);
    rst_n  = 1'b1;
    chk_on = 1'b1;
    first_run = 500 + int'($urandom % 2500);
    repeat (first_run) @(negedge clk);
    chk_on = 1'b0;
    rst_n  = 1'b0;
    hold = 1 + int'($urandom % 4);
    for (int i = 0; i < hold; i++) begin
      #1 reset_all();
      @(negedge clk);
    end
    rst_n  = 1'b1;
    chk_on = 1'b1;
    repeat (RUN_CYCLES) @(negedge clk);
    #1 finish_run();
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule